// File: doc/BRIEF.md
# Misaligned Access Byte-Lane Splitter

This block turns a single load/store request into at most two cache-line row descriptors. The request carries an address, a length code and the number of the unit that issued it. From the low four address bits and the access size, the block builds a 24-lane byte-enable pattern that starts at the byte offset inside a 16-byte half-line.

The lower 16 lanes form the primary row. Any lanes that spill past the half-line form an overflow row, which targets the following line index. Both rows keep the bank select and the upper address field of the request. When the spill would run off the end of the 4 KiB page, the block raises a fault flag and suppresses the overflow row. The primary row is still issued.

All outputs are registered. A request sampled on one clock edge shows up on the outputs after that edge and stays until the next edge. A downstream merge stage can therefore read both rows as a pair in a fixed cycle.

Top module: `lsSplitter`

## Requirements
- R1: While reset is held and after it is released with no request, priValid, ovfValid, misaligned and pageFault are all low.
- R2: Length codes 1, 2, 3 and 4 select 1, 2, 4 and 8 bytes. The 24-lane pattern is that many ones shifted left by address bits [3:0]. priMask bit i equals pattern lane i, for i from 0 to 15.
- R3: ovfMask bits [7:0] equal pattern lanes 23 to 16. ovfMask bits [15:8] are always zero.
- R4: For a request with a legal length code, misaligned is high exactly when the overflow lanes are non-zero.
- R5: priLine equals address bits [11:5]. ovfLine equals address bits [11:5] plus one, modulo 128. The wrap from 127 to 0 is not a fault in itself.
- R6: priBank and ovfBank both equal address bit 4. priUpper and ovfUpper both equal address bits [48:12]. priUnit and ovfUnit both equal the request's unit number.
- R7: pageFault is high when address bits [11:4] are all ones and the overflow lanes are non-zero. When pageFault is high, ovfValid is low and priValid stays high.
- R8: Outputs describe the request sampled at the previous rising edge. If reqValid was low at that edge, priValid, ovfValid, misaligned and pageFault are low.
- R9: Length codes 0, 5, 6 and 7 are illegal. For an illegal code, priValid, ovfValid, misaligned and pageFault are low, and both masks are zero.
- R10: ovfValid is high only when misaligned is high and pageFault is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 49 | Byte address |
| reqLen | input | 3 | Length code (1..4 legal) |
| reqUnit | input | 3 | Issuing unit number |
| priValid | output | 1 | Primary row valid |
| priUnit | output | 3 | Primary row unit number |
| priLine | output | 7 | Primary row line index |
| priBank | output | 1 | Primary row bank select |
| priUpper | output | 37 | Primary row upper address |
| priMask | output | 16 | Primary row byte enables |
| ovfValid | output | 1 | Overflow row valid |
| ovfUnit | output | 3 | Overflow row unit number |
| ovfLine | output | 7 | Overflow row line index |
| ovfBank | output | 1 | Overflow row bank select |
| ovfUpper | output | 37 | Overflow row upper address |
| ovfMask | output | 16 | Overflow row byte enables |
| misaligned | output | 1 | Access spills into the overflow row |
| pageFault | output | 1 | Spill would cross the page boundary |

## Verification
The hardest case to reach is the page-crossing fault. It needs address bits [11:4] all ones and also an offset and size that spill past lane 15. Random addresses hit this only about once in a few thousand requests. The bench therefore steers it directly: it sets address bits [11:4] to all ones and pairs them with offsets close to 15 and the larger sizes. It adds the near-miss cases around it: the same page-top address with an access that fits, and line 127 with bank bit 0, where the line index wraps without a fault. After that, a long random phase with bursts and idle gaps is compared against a behavioural model on every clock.

// File: rtl/lsSplitPkg.sv
`timescale 1ns/1ps
package lsSplitPkg;
  // Strobes driven by the control into the datapath
  typedef struct packed {
    logic load;     // capture the request fields this cycle
    logic legal;    // length code decodes to a real size
  } ctrlStrobes_t;

  // Number of bytes a length code selects; zero for an illegal code
  function automatic logic [4:0] lenToBytes(input logic [2:0] code);
    logic [4:0] n;
    case (code)
      3'd1:    n = 5'd1;
      3'd2:    n = 5'd2;
      3'd3:    n = 5'd4;
      3'd4:    n = 5'd8;
      default: n = 5'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lsSplitData.sv
`timescale 1ns/1ps
module lsSplitData
  import lsSplitPkg::*;
#(
  parameter int ADDR_W     = 49,
  parameter int UNIT_W     = 3,
  parameter int HALF_BYTES = 16,
  parameter int OVF_BYTES  = 8,
  parameter int PAGE_LSB   = 12
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic [2:0]                             reqLen,
  input  logic [UNIT_W-1:0]                      reqUnit,
  input  ctrlStrobes_t                           strobes,
  output logic                                   lenLegal,
  output logic                                   ovfAny,
  output logic                                   pageTop,
  output logic [UNIT_W-1:0]                      unitQ,
  output logic [PAGE_LSB-$clog2(HALF_BYTES)-2:0] priLineQ,
  output logic [PAGE_LSB-$clog2(HALF_BYTES)-2:0] ovfLineQ,
  output logic                                   bankQ,
  output logic [ADDR_W-PAGE_LSB-1:0]             upperQ,
  output logic [HALF_BYTES-1:0]                  priMaskQ,
  output logic [HALF_BYTES-1:0]                  ovfMaskQ
);
  localparam int OFF_W    = $clog2(HALF_BYTES);
  localparam int BANK_BIT = OFF_W;
  localparam int LINE_LSB = OFF_W + 1;
  localparam int LINE_W   = PAGE_LSB - LINE_LSB;
  localparam int UPPER_W  = ADDR_W - PAGE_LSB;
  localparam int SPAN     = HALF_BYTES + OVF_BYTES;
  localparam int IDX_W    = $clog2(SPAN) + 1;
  localparam int PAD_W    = HALF_BYTES - OVF_BYTES;

  logic [OFF_W-1:0]  byteOff;
  logic [4:0]        nBytes;
  logic [IDX_W-1:0]  loIdx;
  logic [IDX_W-1:0]  hiIdx;
  logic [SPAN-1:0]   spanMask;
  logic [LINE_W-1:0] lineNow;

  assign byteOff  = reqAddr[OFF_W-1:0];
  assign nBytes   = lenToBytes(reqLen);
  assign lenLegal = (nBytes != 5'd0);
  assign loIdx    = IDX_W'(byteOff);
  assign hiIdx    = IDX_W'(byteOff) + IDX_W'(nBytes);
  assign lineNow  = reqAddr[PAGE_LSB-1:LINE_LSB];

  // One comparator pair per byte lane
  for (genvar lane = 0; lane < SPAN; lane++) begin : g_lane
    assign spanMask[lane] = (IDX_W'(lane) >= loIdx) && (IDX_W'(lane) < hiIdx);
  end

  assign ovfAny  = |spanMask[SPAN-1:HALF_BYTES];
  assign pageTop = &reqAddr[PAGE_LSB-1:BANK_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitQ    <= '0;
      priLineQ <= '0;
      ovfLineQ <= '0;
      bankQ    <= 1'b0;
      upperQ   <= '0;
      priMaskQ <= '0;
      ovfMaskQ <= '0;
    end else if (strobes.load) begin
      unitQ    <= reqUnit;
      priLineQ <= lineNow;
      ovfLineQ <= lineNow + LINE_W'(1);
      bankQ    <= reqAddr[BANK_BIT];
      upperQ   <= reqAddr[ADDR_W-1:PAGE_LSB];
      priMaskQ <= spanMask[HALF_BYTES-1:0];
      ovfMaskQ <= {{PAD_W{1'b0}}, spanMask[SPAN-1:HALF_BYTES]};
    end
  end

  // R3: upper overflow lanes never carry enables
  assert_ovf_pad_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovfMaskQ[HALF_BYTES-1:OVF_BYTES] == '0);

  // R9: an illegal size captured last cycle leaves both masks empty
  assert_illegal_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.legal) |=> (priMaskQ == '0 && ovfMaskQ == '0));
endmodule

// File: rtl/lsSplitCtrl.sv
`timescale 1ns/1ps
module lsSplitCtrl
  import lsSplitPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         lenLegal,
  input  logic         ovfAny,
  input  logic         pageTop,
  output ctrlStrobes_t strobes,
  output logic         priValidQ,
  output logic         ovfValidQ,
  output logic         misalQ,
  output logic         faultQ
);
  logic takeReq;
  logic spill;
  logic crossPage;

  assign takeReq   = reqValid && lenLegal;
  assign spill     = takeReq && ovfAny;
  assign crossPage = spill && pageTop;

  assign strobes.load  = reqValid;
  assign strobes.legal = lenLegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priValidQ <= 1'b0;
      ovfValidQ <= 1'b0;
      misalQ    <= 1'b0;
      faultQ    <= 1'b0;
    end else begin
      priValidQ <= takeReq;
      misalQ    <= spill;
      faultQ    <= crossPage;
      ovfValidQ <= spill && !crossPage;
    end
  end

  // R10: overflow row only for a spill that stays inside the page
  assert_ovf_needs_spill_R10: assert property (@(posedge clk) disable iff (!rstN)
    ovfValidQ |-> (misalQ && !faultQ));

  // R7: a page-cross flag always comes with a spill and a primary row
  assert_fault_is_misaligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (misalQ && priValidQ && !ovfValidQ));

  // R8: nothing appears without a request at the previous edge
  assert_one_cycle_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!priValidQ && !misalQ && !faultQ && !ovfValidQ));
endmodule

// File: rtl/lsSplitter.sv
`timescale 1ns/1ps
module lsSplitter
  import lsSplitPkg::*;
#(
  parameter int ADDR_W     = 49,
  parameter int UNIT_W     = 3,
  parameter int HALF_BYTES = 16,
  parameter int OVF_BYTES  = 8,
  parameter int PAGE_LSB   = 12,
  localparam int LINE_W    = PAGE_LSB - $clog2(HALF_BYTES) - 1,
  localparam int UPPER_W   = ADDR_W - PAGE_LSB
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2:0]            reqLen,
  input  logic [UNIT_W-1:0]     reqUnit,
  output logic                  priValid,
  output logic [UNIT_W-1:0]     priUnit,
  output logic [LINE_W-1:0]     priLine,
  output logic                  priBank,
  output logic [UPPER_W-1:0]    priUpper,
  output logic [HALF_BYTES-1:0] priMask,
  output logic                  ovfValid,
  output logic [UNIT_W-1:0]     ovfUnit,
  output logic [LINE_W-1:0]     ovfLine,
  output logic                  ovfBank,
  output logic [UPPER_W-1:0]    ovfUpper,
  output logic [HALF_BYTES-1:0] ovfMask,
  output logic                  misaligned,
  output logic                  pageFault
);
  ctrlStrobes_t strobes;
  logic lenLegal;
  logic ovfAny;
  logic pageTop;
  logic [UNIT_W-1:0]  unitQ;
  logic [UPPER_W-1:0] upperQ;
  logic               bankQ;

  lsSplitData #(
    .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .HALF_BYTES(HALF_BYTES),
    .OVF_BYTES(OVF_BYTES), .PAGE_LSB(PAGE_LSB)
  ) data_i (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqUnit(reqUnit), .strobes(strobes), .lenLegal(lenLegal),
    .ovfAny(ovfAny), .pageTop(pageTop), .unitQ(unitQ),
    .priLineQ(priLine), .ovfLineQ(ovfLine), .bankQ(bankQ),
    .upperQ(upperQ), .priMaskQ(priMask), .ovfMaskQ(ovfMask)
  );

  lsSplitCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lenLegal(lenLegal),
    .ovfAny(ovfAny), .pageTop(pageTop), .strobes(strobes),
    .priValidQ(priValid), .ovfValidQ(ovfValid),
    .misalQ(misaligned), .faultQ(pageFault)
  );

  assign priUnit  = unitQ;
  assign ovfUnit  = unitQ;
  assign priBank  = bankQ;
  assign ovfBank  = bankQ;
  assign priUpper = upperQ;
  assign ovfUpper = upperQ;

  // R4: control's spill flag agrees with the datapath's overflow lanes
  assert_misalign_has_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (priValid && (misaligned != (ovfMask != '0))) == 1'b0);

  // R5: overflow row targets the next line
  assert_next_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfValid |-> (ovfLine == priLine + LINE_W'(1)));

  // R2: a valid primary row enables 1, 2, 4 or 8 lanes in total
  assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    priValid |-> ($countones({ovfMask, priMask}) inside {1, 2, 4, 8}));

  // R1: flags stay low throughout reset
  always_ff @(posedge clk) begin
    if (!rstN && $past(!rstN)) begin
      assert_reset_quiet_R1: assert (!priValid && !ovfValid && !misaligned && !pageFault);
    end
  end
endmodule

// File: tb/lsSplitter_tb.sv
`timescale 1ns/1ps
module lsSplitter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [48:0] reqAddr = '0;
  logic [2:0]  reqLen = '0;
  logic [2:0]  reqUnit = '0;

  logic        priValid, ovfValid, misaligned, pageFault, priBank, ovfBank;
  logic [2:0]  priUnit, ovfUnit;
  logic [6:0]  priLine, ovfLine;
  logic [36:0] priUpper, ovfUpper;
  logic [15:0] priMask, ovfMask;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // expected state from the model
  bit          eLoaded = 0;
  bit          ePri = 0, eOvf = 0, eMis = 0, eFault = 0;
  logic [15:0] ePriMask = '0, eOvfMask = '0;
  logic [6:0]  eLine = '0, eOvfLine = '0;
  logic        eBank = 1'b0;
  logic [36:0] eUpper = '0;
  logic [2:0]  eUnit = '0;

  always #10 clk = ~clk;   // 50 MHz

  lsSplitter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqUnit(reqUnit),
    .priValid(priValid), .priUnit(priUnit), .priLine(priLine),
    .priBank(priBank), .priUpper(priUpper), .priMask(priMask),
    .ovfValid(ovfValid), .ovfUnit(ovfUnit), .ovfLine(ovfLine),
    .ovfBank(ovfBank), .ovfUpper(ovfUpper), .ovfMask(ovfMask),
    .misaligned(misaligned), .pageFault(pageFault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R8/R9 priValid", 64'(priValid), 64'(ePri));
    chk("R10 ovfValid", 64'(ovfValid), 64'(eOvf));
    chk("R4 misaligned", 64'(misaligned), 64'(eMis));
    chk("R7 pageFault", 64'(pageFault), 64'(eFault));
    if (eLoaded) begin
      chk("R2 priMask", 64'(priMask), 64'(ePriMask));
      chk("R3 ovfMask", 64'(ovfMask), 64'(eOvfMask));
      chk("R5 priLine", 64'(priLine), 64'(eLine));
      chk("R5 ovfLine", 64'(ovfLine), 64'(eOvfLine));
      chk("R6 bank", 64'({priBank, ovfBank}), 64'({eBank, eBank}));
      chk("R6 upper", 64'(priUpper), 64'(eUpper));
      chk("R6 ovfUpper", 64'(ovfUpper), 64'(eUpper));
      chk("R6 unit", 64'({priUnit, ovfUnit}), 64'({eUnit, eUnit}));
    end
  endtask

  // Check last cycle's result, then apply a new request and predict it
  task automatic step(input bit v, input logic [48:0] a, input logic [2:0] len, input logic [2:0] u);
    int nb;
    logic [31:0] pat;
    @(negedge clk);
    compareAll();
    reqValid = v; reqAddr = a; reqLen = len; reqUnit = u;
    nb = (len >= 3'd1 && len <= 3'd4) ? (1 << (int'(len) - 1)) : 0;
    pat = ((32'd1 << nb) - 32'd1) << a[3:0];
    if (v) begin
      eLoaded  = 1;
      ePriMask = pat[15:0];
      eOvfMask = {8'h00, pat[23:16]};
      eLine    = a[11:5];
      eOvfLine = 7'((int'(a[11:5]) + 1) % 128);
      eBank    = a[4];
      eUpper   = a[48:12];
      eUnit    = u;
    end
    ePri   = v && (nb != 0);
    eMis   = ePri && (pat[23:16] != 8'h00);
    eFault = eMis && (a[11:4] == 8'hFF);
    eOvf   = eMis && !eFault;
  endtask

  function automatic logic [48:0] mkAddr(input logic [36:0] up, input logic [6:0] line,
                                         input logic bank, input logic [3:0] off);
    return {up, line, bank, off};
  endfunction

  initial begin
    // R1: reset holds flags low
    repeat (3) @(negedge clk);
    chk("R1 reset priValid", 64'(priValid), 64'd0);
    chk("R1 reset ovfValid", 64'(ovfValid), 64'd0);
    chk("R1 reset flags", 64'({misaligned, pageFault}), 64'd0);
    rstN = 1'b1;
    step(0, '0, 3'd0, 3'd0);
    step(0, '0, 3'd0, 3'd0);   // R1: idle after reset

    // R2: every size at offset 0, fully aligned
    for (int l = 1; l <= 4; l++) step(1, mkAddr(37'h1234, 7'd3, 1'b0, 4'd0), 3'(l), 3'(l));
    // R2/R3/R4: every size at every offset
    for (int o = 0; o < 16; o++)
      for (int l = 1; l <= 4; l++)
        step(1, mkAddr(37'h0ABCDE, 7'd40, 1'b1, 4'(o)), 3'(l), 3'(o));
    // R7: page-top with spills -> fault, primary still issued
    step(1, mkAddr(37'h77, 7'h7F, 1'b1, 4'd15), 3'd2, 3'd5);
    step(1, mkAddr(37'h77, 7'h7F, 1'b1, 4'd9),  3'd4, 3'd6);
    step(1, mkAddr(37'h77, 7'h7F, 1'b1, 4'd14), 3'd3, 3'd7);
    // R7: page-top, access fits -> no fault
    step(1, mkAddr(37'h77, 7'h7F, 1'b1, 4'd8),  3'd4, 3'd1);
    // R5: line 127 with bank 0 wraps without fault
    step(1, mkAddr(37'h55, 7'h7F, 1'b0, 4'd12), 3'd4, 3'd2);
    // R9: illegal codes, including one with a spilling offset
    step(1, mkAddr(37'h9, 7'h7F, 1'b1, 4'd15), 3'd0, 3'd3);
    step(1, mkAddr(37'h9, 7'd1, 1'b0, 4'd15), 3'd5, 3'd3);
    step(1, mkAddr(37'h9, 7'd1, 1'b0, 4'd9),  3'd6, 3'd3);
    step(1, mkAddr(37'h9, 7'd1, 1'b0, 4'd0),  3'd7, 3'd3);
    // R8: request then idle drops the flags
    step(1, mkAddr(37'h3, 7'd9, 1'b1, 4'd13), 3'd4, 3'd4);
    step(0, mkAddr(37'h3, 7'd9, 1'b1, 4'd13), 3'd4, 3'd4);
    step(0, '0, 3'd1, 3'd0);

    // Random phase with bursts and gaps, biased towards the page top
    for (int i = 0; i < 3000; i++) begin
      logic [48:0] a;
      a = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) a[11:4] = 8'hFF;
      step($urandom_range(0, 3) != 0, a, 3'($urandom_range(0, 7)), 3'($urandom()));
    end
    step(0, '0, 3'd0, 3'd0);
    step(0, '0, 3'd0, 3'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule